// File: doc/BRIEF.md
# Memory Bank Steering Predictor

In a group of cores fused into one wide core, each core owns one bank of the shared load/store queue. The bank for a memory operation is a field of its effective address, but the operation must be sent to a queue before that address exists. This block guesses the bank from the instruction PC when the operation is steered. It checks the guess once the address has been generated. When the guess was wrong, it raises a re-steer toward the right bank.

The predictor is a direct-mapped table indexed by low PC bits. Each entry holds a bank number and a two-bit confidence counter. Every resolution in fused mode trains the entry and reports the update. When the cores run split, each core uses only its own bank, given on `home_bank_i`. In that mode the prediction and the resolved bank both equal that home bank, and the table stays untouched. A re-steer is held in one register until the queue side accepts it. While it waits, the block refuses new resolutions, so no more than one re-steer is ever in flight.

Top module: `bank_steer_pred`

## Requirements
- R1: In fused mode the resolved bank `correct_bank_o` is address bits [BANK_LSB+1:BANK_LSB], which lie above the index field and below the tag (BANK_LSB = 10 by default).
- R2: In fused mode `pred_bank_o` is the bank stored in the entry indexed by `steer_pc_i[PC_LSB+IDX_W-1:PC_LSB]` (bits [7:2] by default), read in the same cycle.
- R3: After reset every entry predicts bank 0 with confidence 0.
- R4: An accepted resolution whose resolved bank differs from `res_pred_bank_i` asserts `mispredict_o` in the same cycle. The right bank appears on `correct_bank_o`.
- R5: On an accepted fused resolution, the entry is trained against its stored bank. If the resolved bank matches, the confidence rises, saturating at 3. If it differs and the confidence is above 0, the confidence falls by one and the stored bank is kept. If it differs and the confidence is 0, the stored bank is replaced by the resolved bank and the confidence stays 0.
- R6: A mispredict raises `resteer_valid_o` one cycle later, carrying the right bank and the PC. The request stays valid and unchanged until `resteer_ready_i` is high at a clock edge, and it clears in the next cycle.
- R7: `res_ready_o` is low while a re-steer is pending. A resolution offered in that state is ignored: it produces no mispredict, no update and no table change.
- R8: In split mode (`fused_i` = 0) both the prediction and the resolved bank equal `home_bank_i`, and the table is not written.
- R9: One cycle after each accepted fused resolution, `upd_valid_o` pulses for one cycle. `upd_idx_o` gives the entry index and `upd_bank_o` gives the bank the entry now holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fused_i | input | 1 | 1 = fused mode, 0 = split mode |
| home_bank_i | input | 2 | Local core bank used in split mode |
| steer_pc_i | input | PC_W | PC of the operation being steered |
| pred_bank_o | output | 2 | Predicted bank |
| res_valid_i | input | 1 | Resolution offered |
| res_ready_o | output | 1 | Resolution accepted when high |
| res_pc_i | input | PC_W | PC of the resolving operation |
| res_addr_i | input | ADDR_W | Effective address |
| res_pred_bank_i | input | 2 | Bank the operation was steered to |
| mispredict_o | output | 1 | Accepted resolution went to the wrong bank |
| correct_bank_o | output | 2 | Bank the address maps to |
| resteer_valid_o | output | 1 | Pending re-steer request |
| resteer_ready_i | input | 1 | Target bank accepts the re-steer |
| resteer_bank_o | output | 2 | Target bank of the re-steer |
| resteer_pc_o | output | PC_W | PC of the re-steered operation |
| upd_valid_o | output | 1 | Table update report |
| upd_idx_o | output | IDX_W | Updated entry index |
| upd_bank_o | output | 2 | Bank held by the entry after the update |

## Verification
The bench drives several hundred resolutions over a small set of hot entries and follows a running model of the table, so every confidence transition happens many times. A design that replaced the bank on the first miss, let the counter wrap past 3, or trained against the steered bank rather than the stored one would soon predict a different bank than the model. The bench holds a re-steer back for several cycles and offers a resolution meanwhile. A design that dropped or changed the pending request, or accepted the blocked resolution, shows a wrong `resteer_*` value or an unexpected update. A stretch in split mode with mixed home banks catches any table write or address-derived bank in that mode.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int BANK_W = 2;
  localparam int CONF_W = 2;
  localparam logic [CONF_W-1:0] CONF_MAX = '1;

  typedef logic [BANK_W-1:0] bank_t;

  typedef struct packed {
    bank_t             bank;
    logic [CONF_W-1:0] conf;
  } bsp_entry_t;
endpackage

// File: rtl/bsp_field.sv
module bsp_field #(
  parameter int ADDR_W   = 32,
  parameter int BANK_LSB = 10
) (
  input  logic              fused_i,
  input  bsp_pkg::bank_t    home_bank_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bsp_pkg::bank_t    bank_o
);
  // bank field sits between tag (above) and index (below)
  assign bank_o = fused_i ? addr_i[BANK_LSB +: bsp_pkg::BANK_W] : home_bank_i;
endmodule

// File: rtl/bsp_table.sv
module bsp_table
  import bsp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output bank_t            rd_bank_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  bank_t            wr_bank_i,
  output bank_t            new_bank_o
);
  localparam int DEPTH = 1 << IDX_W;

  bsp_entry_t tbl_q [DEPTH];
  bsp_entry_t cur, nxt;

  assign rd_bank_o = tbl_q[rd_idx_i].bank;
  assign cur       = tbl_q[wr_idx_i];

  always_comb begin
    nxt = cur;
    if (cur.bank == wr_bank_i) begin
      if (cur.conf != CONF_MAX) nxt.conf = cur.conf + 1'b1;
    end else if (cur.conf != '0) begin
      nxt.conf = cur.conf - 1'b1;
    end else begin
      nxt.bank = wr_bank_i;
    end
  end

  assign new_bank_o = nxt.bank;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/bsp_resteer.sv
module bsp_resteer #(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  bsp_pkg::bank_t  bank_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ready_i,
  output logic            valid_o,
  output bsp_pkg::bank_t  bank_o,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      bank_o  <= '0;
      pc_o    <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      bank_o  <= bank_i;
      pc_o    <= pc_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_steer_pred.sv
module bank_steer_pred
  import bsp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 6,
  parameter int PC_LSB   = 2,
  parameter int BANK_LSB = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fused_i,
  input  logic [1:0]        home_bank_i,
  input  logic [PC_W-1:0]   steer_pc_i,
  output logic [1:0]        pred_bank_o,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  input  logic [PC_W-1:0]   res_pc_i,
  input  logic [ADDR_W-1:0] res_addr_i,
  input  logic [1:0]        res_pred_bank_i,
  output logic              mispredict_o,
  output logic [1:0]        correct_bank_o,
  output logic              resteer_valid_o,
  input  logic              resteer_ready_i,
  output logic [1:0]        resteer_bank_o,
  output logic [PC_W-1:0]   resteer_pc_o,
  output logic              upd_valid_o,
  output logic [IDX_W-1:0]  upd_idx_o,
  output logic [1:0]        upd_bank_o
);
  logic [IDX_W-1:0] rd_idx, wr_idx;
  bank_t            rd_bank, act_bank, new_bank;
  logic             accept, wr_en;
  logic             unused_bits;

  assign rd_idx      = steer_pc_i[PC_LSB +: IDX_W];
  assign wr_idx      = res_pc_i[PC_LSB +: IDX_W];
  assign unused_bits = ^{steer_pc_i, res_addr_i};

  assign res_ready_o = !resteer_valid_o;
  assign accept      = res_valid_i && res_ready_o;
  assign wr_en       = accept && fused_i;

  bsp_field #(.ADDR_W(ADDR_W), .BANK_LSB(BANK_LSB)) u_field (
    .fused_i     (fused_i),
    .home_bank_i (home_bank_i),
    .addr_i      (res_addr_i),
    .bank_o      (act_bank)
  );

  bsp_table #(.IDX_W(IDX_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_bank_o  (rd_bank),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_bank_i  (act_bank),
    .new_bank_o (new_bank)
  );

  assign pred_bank_o    = fused_i ? rd_bank : home_bank_i;
  assign correct_bank_o = act_bank;
  assign mispredict_o   = accept && (act_bank != res_pred_bank_i);

  bsp_resteer #(.PC_W(PC_W)) u_resteer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (mispredict_o),
    .bank_i  (act_bank),
    .pc_i    (res_pc_i),
    .ready_i (resteer_ready_i),
    .valid_o (resteer_valid_o),
    .bank_o  (resteer_bank_o),
    .pc_o    (resteer_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_valid_o <= 1'b0;
      upd_idx_o   <= '0;
      upd_bank_o  <= '0;
    end else begin
      upd_valid_o <= wr_en;
      if (wr_en) begin
        upd_idx_o  <= wr_idx;
        upd_bank_o <= new_bank;
      end
    end
  end
endmodule

// File: rtl/bsp_checker.sv
module bsp_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fused_i,
  input logic [1:0] home_bank_i,
  input logic       res_valid_i,
  input logic       res_ready_o,
  input logic [1:0] res_pred_bank_i,
  input logic       mispredict_o,
  input logic       resteer_valid_o,
  input logic       resteer_ready_i,
  input logic [1:0] resteer_bank_o,
  input logic       upd_valid_o
);
  assert_resteer_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resteer_valid_o && !resteer_ready_i |=> resteer_valid_o && $stable(resteer_bank_o));

  assert_mispredict_raises_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |=> resteer_valid_o);

  assert_blocked_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_ready_o |-> !mispredict_o);

  assert_upd_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(res_valid_i && res_ready_o && fused_i));

  assert_split_home_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fused_i && res_pred_bank_i == home_bank_i |-> !mispredict_o);

  assert_single_resteer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resteer_valid_o && !resteer_ready_i |-> !mispredict_o);
endmodule

bind bank_steer_pred bsp_checker u_bsp_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .fused_i         (fused_i),
  .home_bank_i     (home_bank_i),
  .res_valid_i     (res_valid_i),
  .res_ready_o     (res_ready_o),
  .res_pred_bank_i (res_pred_bank_i),
  .mispredict_o    (mispredict_o),
  .resteer_valid_o (resteer_valid_o),
  .resteer_ready_i (resteer_ready_i),
  .resteer_bank_o  (resteer_bank_o),
  .upd_valid_o     (upd_valid_o)
);

// File: tb/bank_steer_pred_tb.sv
module bank_steer_pred_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32, ADDR_W = 32, IDX_W = 6, PC_LSB = 2, BANK_LSB = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fused, res_valid, res_ready, mispred, rs_valid, rs_ready, upd_valid;
  logic [1:0] home, pred_bank, res_pred, corr_bank, rs_bank, upd_bank;
  logic [PC_W-1:0] steer_pc, res_pc, rs_pc;
  logic [ADDR_W-1:0] res_addr;
  logic [IDX_W-1:0] upd_idx;

  int tests = 0, fails = 0;
  logic [1:0] m_bank [64];
  logic [1:0] m_conf [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_steer_pred u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fused_i(fused), .home_bank_i(home),
    .steer_pc_i(steer_pc), .pred_bank_o(pred_bank),
    .res_valid_i(res_valid), .res_ready_o(res_ready), .res_pc_i(res_pc),
    .res_addr_i(res_addr), .res_pred_bank_i(res_pred),
    .mispredict_o(mispred), .correct_bank_o(corr_bank),
    .resteer_valid_o(rs_valid), .resteer_ready_i(rs_ready),
    .resteer_bank_o(rs_bank), .resteer_pc_o(rs_pc),
    .upd_valid_o(upd_valid), .upd_idx_o(upd_idx), .upd_bank_o(upd_bank)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic resolve(input logic [PC_W-1:0] pc, input logic [ADDR_W-1:0] a,
                         input logic [1:0] pb, input int hold);
    int idx = int'(pc[PC_LSB +: IDX_W]);
    logic [1:0] act = fused ? a[BANK_LSB +: 2] : home;
    logic mp = (act != pb);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_addr = a; res_pred = pb;
    #1;
    chk("R1/R8 correct_bank", corr_bank, act);
    chk("R4 mispredict", mispred, mp);
    @(negedge clk);
    res_valid = 1'b0;
    if (fused) begin
      if (m_bank[idx] == act) begin
        if (m_conf[idx] != 2'd3) m_conf[idx]++;
      end else if (m_conf[idx] != 0) m_conf[idx]--;
      else m_bank[idx] = act;
    end
    #1;
    chk("R9 upd_valid", upd_valid, fused);
    if (fused) begin
      chk("R9 upd_idx", upd_idx, idx);
      chk("R9 upd_bank", upd_bank, m_bank[idx]);
    end
    chk("R6 resteer_valid", rs_valid, mp);
    if (mp) begin
      chk("R6 resteer_bank", rs_bank, act);
      chk("R6 resteer_pc", int'(rs_pc == pc), 1);
      chk("R7 res_ready low", res_ready, 0);
      for (int k = 0; k < hold; k++) begin
        @(negedge clk); #1;
        chk("R6 held valid", rs_valid, 1);
        chk("R6 held bank", rs_bank, act);
      end
      rs_ready = 1'b1;
      @(negedge clk);
      rs_ready = 1'b0;
      #1;
      chk("R6 cleared", rs_valid, 0);
      chk("R7 res_ready back", res_ready, 1);
    end
  endtask

  initial begin
    fused = 1'b1; home = '0; steer_pc = '0; res_valid = 1'b0; res_pc = '0;
    res_addr = '0; res_pred = '0; rs_ready = 1'b0;
    for (int i = 0; i < 64; i++) begin m_bank[i] = '0; m_conf[i] = '0; end
    #(CLK_PERIOD * 3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset resteer", rs_valid, 0);
    chk("R9 reset upd", upd_valid, 0);
    for (int i = 0; i < 64; i++) begin
      steer_pc = 32'(i << PC_LSB); #1;
      chk("R3 reset pred", pred_bank, 0);
    end

    for (int n = 0; n < 420; n++) begin
      int idx = (n * 7) % 16;
      logic [PC_W-1:0] pc = 32'h4000_0000 | 32'(idx << PC_LSB) | 32'((n % 3) << 12);
      logic [1:0] bk = 2'(((n / 3) ^ (n >> 4)) % 4);
      logic [ADDR_W-1:0] a = 32'(n * 32'h1_0033) & ~(32'h3 << BANK_LSB) | (32'(bk) << BANK_LSB);
      logic [1:0] pb;
      fused = !(n >= 200 && n < 240);
      home = 2'(n % 4);
      steer_pc = pc;
      @(negedge clk); #1;
      chk(fused ? "R2 pred_bank" : "R8 split pred", pred_bank, fused ? m_bank[idx] : home);
      pb = (n % 5 == 0) ? pred_bank + 2'd1 : pred_bank;
      resolve(pc, a, pb, n % 4);
      if (!fused) begin
        fused = 1'b1; #1;
        chk("R8 table frozen", pred_bank, m_bank[idx]);
      end
    end

    // R5 directed: saturation then drain and replace on entry 40
    fused = 1'b1;
    for (int k = 0; k < 5; k++) resolve(32'(40 << PC_LSB), 32'(2 << BANK_LSB), 2'd0, 0);
    for (int k = 0; k < 4; k++) begin
      steer_pc = 32'(40 << PC_LSB); #1;
      chk("R5 kept while confident", pred_bank, 2);
      resolve(32'(40 << PC_LSB), 32'(1 << BANK_LSB), 2'd2, 0);
    end
    steer_pc = 32'(40 << PC_LSB); #1;
    chk("R5 replaced at zero", pred_bank, 1);

    // R7: resolution offered while re-steer pending is ignored
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'(50 << PC_LSB); res_addr = 32'(3 << BANK_LSB); res_pred = 2'd0;
    @(negedge clk);
    res_pc = 32'(51 << PC_LSB); res_addr = 32'(2 << BANK_LSB);
    #1;
    chk("R7 blocked no mispredict", mispred, 0);
    chk("R7 pending bank", rs_bank, 3);
    @(negedge clk);
    res_valid = 1'b0; #1;
    chk("R7 blocked no update", upd_valid, 0);
    steer_pc = 32'(51 << PC_LSB); #1;
    chk("R7 table untouched", pred_bank, 0);
    rs_ready = 1'b1;
    @(negedge clk);
    rs_ready = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule